// File: doc/BRIEF.md
# Serial Peripheral Master with Bus Collision Detection

This block is an SPI master that exchanges one character per transfer. The character is between one and eight bits long, and the host chooses the length on every transfer. The block drives the serial clock and the serial data output. It samples the serial data input, and it can drive an active-low slave select. Any of the four clock phase and polarity combinations can be used. A divider of the system clock sets the serial clock rate: each half period of the serial clock lasts a programmed number of system clocks plus one.

The host starts a transfer with a one-cycle start strobe. The transmit word, length, divider, phase and polarity are captured on that strobe. A busy flag stays high while the transfer runs. When the transfer ends, the received character appears zero-extended on the receive word.

In multi-master mode the slave-select pin acts as an input and must stay high. If it is low while a transfer runs, or when a start is requested, the block does three things: it records a sticky collision flag, it drops or refuses the transfer, and it releases its clock and data drivers. The host clears the flag with a one-cycle clear strobe.

Top module: `spim_master`

## Requirements
- R1: A transfer of N bits has exactly N receive edges and 2N serial clock transitions, the last one returning the clock to idle. N is `len_i`, and a `len_i` of 0 means 8.
- R2: `mosi_o` carries the low N bits of the captured transmit word, starting with bit N-1, and each bit is stable at its receive edge. At the end of the transfer, `rx_data_o` holds the N bits sampled from `miso_i`, with the first sampled bit at position N-1 and zeros above.
- R3: When no transfer is running, `sck_o` equals `cpol_i`. The receive edge is rising when `cpha_i` equals `cpol_i` and falling otherwise, and the transmit edge is the opposite edge.
- R4: Each half period of `sck_o` lasts `div_i`+1 system clocks. `busy_o` rises in the cycle after an accepted start and stays high for exactly 2N(`div_i`+1) cycles.
- R5: A start strobe while `busy_o` is high is ignored. The running transfer keeps its length, timing and data.
- R6: With `multi_i`=0, `ss_oe_o` and `oe_o` are 1, `ss_n_o` is 0 exactly while busy, and a low `ss_n_i` has no effect.
- R7: With `multi_i`=1, `ss_oe_o` is 0 and `oe_o` is 1 only while busy.
- R8: With `multi_i`=1, a low `ss_n_i` during a transfer ends it in the next cycle. At that point `busy_o` is 0, `coll_o` is 1, `oe_o` is 0, `sck_o` is idle and `rx_data_o` is unchanged.
- R9: With `multi_i`=1, a start while `ss_n_i` is low starts no transfer and sets `coll_o`.
- R10: `coll_o` stays set until a `coll_clr_i` pulse. When a set and a clear arrive in the same cycle, the set wins.
- R11: After reset, `busy_o` is 0, `coll_o` is 0, `rx_data_o` is 0 and `mosi_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| tx_data_i | input | 8 | Transmit word; the low N bits are sent |
| len_i | input | 3 | Character length, 0 meaning 8 |
| div_i | input | 8 | Half period of the serial clock minus one, in system clocks |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase select |
| multi_i | input | 1 | Multi-master mode |
| coll_clr_i | input | 1 | Clears the collision flag |
| rx_data_o | output | 8 | Received character, zero-extended |
| busy_o | output | 1 | Transfer in progress |
| coll_o | output | 1 | Sticky collision flag |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| oe_o | output | 1 | Drive enable for `sck_o` and `mosi_o` |
| ss_n_o | output | 1 | Active-low slave select out |
| ss_oe_o | output | 1 | Drive enable for the slave select |
| ss_n_i | input | 1 | Slave-select pin as an input |

## Verification
The bench acts as a slave in all four clock modes. It counts clock transitions and checks the direction of each one. A design that swapped the phase rule would sample on the transmit edge, and the received character would come back shifted by one bit. The bench covers one-bit and eight-bit characters, the length code 0 and a divider of 0. These cases catch an off-by-one in the half-period count, which would shows up as a wrong busy length or a missing final clock transition. Collisions are raised at random points within a transfer, at start time together with a clear, and as a low select in single-master mode. A design that finished the character, lost the flag, kept driving the bus or let the clear win would be caught.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } spim_edge_e;

  // Receive edge: rising when phase and polarity bits agree.
  function automatic spim_edge_e rx_edge_of(input logic cpha, input logic cpol);
    return (cpha ~^ cpol) ? EDGE_RISE : EDGE_FALL;
  endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);

  logic [DIV_W-1:0] cnt_q;

  assign half_tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || half_tick) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          sample_en,
  input  logic          shift_en,
  input  logic          miso,
  output logic          mosi_bit,
  output logic [DW-1:0] next_word
);

  logic [DW-1:0] sh_q;
  logic          samp_q;

  assign mosi_bit  = sh_q[DW-1];
  assign next_word = {sh_q[DW-2:0], samp_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      samp_q <= 1'b0;
    end else begin
      if (load)          sh_q <= load_val;
      else if (shift_en) sh_q <= next_word;
      if (sample_en)     samp_q <= miso;
    end
  end

endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [DATA_W-1:0]          tx_data_i,
  input  logic [$clog2(DATA_W)-1:0]  len_i,
  input  logic [DIV_W-1:0]           div_i,
  input  logic                       cpol_i,
  input  logic                       cpha_i,
  input  logic                       multi_i,
  input  logic                       coll_clr_i,
  output logic [DATA_W-1:0]          rx_data_o,
  output logic                       busy_o,
  output logic                       coll_o,
  output logic                       sck_o,
  output logic                       mosi_o,
  input  logic                       miso_i,
  output logic                       oe_o,
  output logic                       ss_n_o,
  output logic                       ss_oe_o,
  input  logic                       ss_n_i
);

  localparam int LEN_W = $clog2(DATA_W);
  localparam int NB_W  = LEN_W + 1;
  localparam int HC_W  = $clog2(2 * DATA_W);

  function automatic logic [NB_W-1:0] bits_of(input logic [LEN_W-1:0] l);
    return (l == '0) ? NB_W'(DATA_W) : {1'b0, l};
  endfunction

  function automatic logic [DATA_W-1:0] align_tx(input logic [DATA_W-1:0] d,
                                                 input logic [NB_W-1:0]   n);
    return d << (NB_W'(DATA_W) - n);
  endfunction

  function automatic logic [DATA_W-1:0] mask_of(input logic [NB_W-1:0] n);
    logic [DATA_W:0] m;
    m = ((DATA_W+1)'(1) << n) - 1'b1;
    return m[DATA_W-1:0];
  endfunction

  logic              busy_q, coll_q;
  logic [HC_W-1:0]   hcnt_q;
  logic              c_cpol_q, c_cpha_q;
  logic [DIV_W-1:0]  c_div_q;
  logic [NB_W-1:0]   c_nbits_q;
  logic [DATA_W-1:0] rx_q;

  // Named internal events.
  logic              ss_bad, accept, refuse, abort;
  logic              half_tick, last_half, done;
  logic              sample_en, shift_en, sck_act;
  logic              mosi_bit;
  logic [DATA_W-1:0] next_word;
  logic [HC_W:0]     last_idx;
  spim_edge_e        rx_edge;

  assign ss_bad    = multi_i && !ss_n_i;
  assign accept    = start_i && !busy_q && !ss_bad;
  assign refuse    = start_i && !busy_q && ss_bad;
  assign abort     = busy_q && ss_bad;
  assign last_idx  = (HC_W+1)'({c_nbits_q, 1'b0}) - 1'b1;
  assign last_half = ({1'b0, hcnt_q} == last_idx);
  assign done      = half_tick && last_half && !abort;
  assign sample_en = half_tick && !hcnt_q[0];
  assign shift_en  = half_tick && hcnt_q[0];
  assign sck_act   = c_cpha_q ? ~hcnt_q[0] : hcnt_q[0];
  assign rx_edge   = rx_edge_of(c_cpha_q, c_cpol_q);

  spim_baud #(.DIV_W(DIV_W)) baud_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_q),
    .div       (c_div_q),
    .half_tick (half_tick)
  );

  spim_shift #(.DW(DATA_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  (align_tx(tx_data_i, bits_of(len_i))),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .miso      (miso_i),
    .mosi_bit  (mosi_bit),
    .next_word (next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      coll_q    <= 1'b0;
      hcnt_q    <= '0;
      c_cpol_q  <= 1'b0;
      c_cpha_q  <= 1'b0;
      c_div_q   <= '0;
      c_nbits_q <= NB_W'(DATA_W);
      rx_q      <= '0;
    end else begin
      if (accept) begin
        busy_q    <= 1'b1;
        hcnt_q    <= '0;
        c_cpol_q  <= cpol_i;
        c_cpha_q  <= cpha_i;
        c_div_q   <= div_i;
        c_nbits_q <= bits_of(len_i);
      end else begin
        if (abort || done) busy_q <= 1'b0;
        if (half_tick)     hcnt_q <= hcnt_q + 1'b1;
      end
      if (abort || refuse) coll_q <= 1'b1;
      else if (coll_clr_i) coll_q <= 1'b0;
      if (done) rx_q <= next_word & mask_of(c_nbits_q);
    end
  end

  assign busy_o    = busy_q;
  assign coll_o    = coll_q;
  assign rx_data_o = rx_q;
  assign sck_o     = busy_q ? (c_cpol_q ^ sck_act) : cpol_i;
  assign mosi_o    = busy_q & mosi_bit;
  assign oe_o      = multi_i ? busy_q : 1'b1;
  assign ss_n_o    = ~busy_q;
  assign ss_oe_o   = ~multi_i;

  // Assertions
  a_r8_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && multi_i && !ss_n_i) |=> (!busy_o && coll_o));

  a_r9_refuse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && multi_i && !ss_n_i) |=> (!busy_o && coll_o));

  a_r10_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_o && !coll_clr_i) |=> coll_o);

  a_r5_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !half_tick && !abort) |=> $stable(mosi_o));

  a_r4_sck_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !half_tick && !abort) |=> $stable(sck_o));

  a_r3_rx_edge_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !abort) |=> (sck_o == (rx_edge == EDGE_RISE)));

endmodule

// File: tb/spim_master_tb_top.sv
module spim_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0, multi_i = 1'b0;
  logic       coll_clr_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
  logic [7:0] tx_data_i = '0, div_i = '0;
  logic [2:0] len_i = '0;
  logic [7:0] rx_data_o;
  logic       busy_o, coll_o, sck_o, mosi_o, oe_o, ss_n_o, ss_oe_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spim_master dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_data_i(tx_data_i),
    .len_i(len_i), .div_i(div_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .multi_i(multi_i), .coll_clr_i(coll_clr_i), .rx_data_o(rx_data_o),
    .busy_o(busy_o), .coll_o(coll_o), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .oe_o(oe_o), .ss_n_o(ss_n_o), .ss_oe_o(ss_oe_o),
    .ss_n_i(ss_n_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input int len);
    return (len == 0) ? 8 : len;
  endfunction

  function automatic int busy_cycles(input int n, input int d);
    return 2 * n * (d + 1);
  endfunction

  // Level of the clock just after a receive edge.
  function automatic bit rx_level(input bit cpha, input bit cpol);
    return !(cpha ^ cpol);
  endfunction

  function automatic logic [7:0] keep_low(input logic [7:0] v, input int n);
    logic [7:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic xfer(input bit cpol, input bit cpha, input int len, input int div,
                      input logic [7:0] tx, input logic [7:0] slv,
                      input bit multi, input bit poke, input bit ss_in);
    int n = nbits(len);
    int cnt = 0, edges = 0, redges = 0;
    bit prev, ok_mosi = 1, ok_pins = 1;
    @(negedge clk);
    cpol_i = cpol; cpha_i = cpha; len_i = 3'(len); div_i = 8'(div);
    tx_data_i = tx; multi_i = multi; ss_n_i = ss_in;
    miso_i = slv[n-1];
    start_i = 1'b1;
    prev = cpol;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o && cnt < 5000) begin
      cnt++;
      start_i = poke && (cnt == 3);
      if (poke && cnt == 3) tx_data_i = ~tx;
      if (sck_o !== prev) begin
        edges++;
        if (sck_o == rx_level(cpha, cpol)) begin
          if (redges < n && mosi_o !== tx[n-1-redges]) ok_mosi = 0;
          redges++;
          if (redges < n) miso_i = slv[n-1-redges];
        end
        prev = sck_o;
      end
      if (multi) begin
        if (ss_oe_o !== 1'b0 || oe_o !== 1'b1) ok_pins = 0;
      end else if (ss_n_o !== 1'b0 || ss_oe_o !== 1'b1 || oe_o !== 1'b1) ok_pins = 0;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (sck_o !== prev) edges++;
    chk(cnt == busy_cycles(n, div), "R4 busy length", cnt, busy_cycles(n, div));
    chk(edges == 2 * n, "R1 clock transitions", edges, 2 * n);
    chk(redges == n, "R1/R3 receive edges", redges, n);
    chk(ok_mosi, "R2 mosi bits", 0, 1);
    chk(rx_data_o == keep_low(slv, n), "R2 rx data", rx_data_o, keep_low(slv, n));
    chk(sck_o == cpol, "R3 idle level", sck_o, cpol);
    if (multi) begin
      chk(ok_pins, "R7 pins while busy", 0, 1);
      chk(oe_o == 1'b0, "R7 release after", oe_o, 0);
    end else begin
      chk(ok_pins, "R6 pins while busy", 0, 1);
      chk(ss_n_o == 1'b1, "R6 select after", ss_n_o, 1);
    end
    if (poke) chk(1'b1, "R5 start during busy ignored", 0, 0);
    ss_n_i = 1'b1;
  endtask

  task automatic coll_mid(input bit cpol, input bit cpha, input int k);
    logic [7:0] prev_rx;
    prev_rx = rx_data_o;
    @(negedge clk);
    cpol_i = cpol; cpha_i = cpha; len_i = 3'd0; div_i = 8'd1;
    tx_data_i = 8'($urandom); multi_i = 1'b1; ss_n_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (k) @(negedge clk);
    chk(busy_o == 1'b1, "R8 busy before collision", busy_o, 1);
    ss_n_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R8 busy dropped", busy_o, 0);
    chk(coll_o == 1'b1, "R8 flag set", coll_o, 1);
    chk(oe_o == 1'b0, "R8 drivers released", oe_o, 0);
    chk(sck_o == cpol, "R8 clock idle", sck_o, cpol);
    chk(rx_data_o == prev_rx, "R8 rx unchanged", rx_data_o, prev_rx);
    ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(coll_o == 1'b1, "R10 flag sticky", coll_o, 1);
    coll_clr_i = 1'b1;
    @(negedge clk);
    coll_clr_i = 1'b0;
    chk(coll_o == 1'b0, "R10 flag cleared", coll_o, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    cpol_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0, "R11 busy at reset", busy_o, 0);
    chk(coll_o == 0, "R11 coll at reset", coll_o, 0);
    chk(rx_data_o == 0, "R11 rx at reset", rx_data_o, 0);
    chk(mosi_o == 0, "R11 mosi at reset", mosi_o, 0);
    chk(sck_o == 1, "R3 idle at reset", sck_o, 1);

    // Directed: all four modes, full length, fastest divider
    for (int m = 0; m < 4; m++)
      xfer(m[1], m[0], 0, 0, 8'hA5, 8'h3C, 0, 0, 1);
    // One-bit and eight-bit characters, slow divider
    xfer(0, 1, 1, 3, 8'h01, 8'h01, 0, 0, 1);
    xfer(1, 0, 1, 0, 8'hFE, 8'hFF, 1, 0, 1);
    xfer(1, 1, 0, 5, 8'h81, 8'h7E, 1, 0, 1);
    // R5: start pulse in the middle of a transfer
    xfer(0, 0, 5, 2, 8'h15, 8'h0A, 0, 1, 1);
    // R6: low select input ignored in single-master mode
    xfer(1, 0, 7, 1, 8'h55, 8'h2B, 0, 0, 0);
    chk(coll_o == 0, "R6 no collision in single mode", coll_o, 0);

    // R9 + R10: refused start with simultaneous clear, set wins
    @(negedge clk);
    multi_i = 1'b1; ss_n_i = 1'b0; start_i = 1'b1; coll_clr_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; coll_clr_i = 1'b0;
    chk(busy_o == 0, "R9 start refused", busy_o, 0);
    chk(coll_o == 1, "R9/R10 set wins over clear", coll_o, 1);
    ss_n_i = 1'b1; coll_clr_i = 1'b1;
    @(negedge clk);
    coll_clr_i = 1'b0;
    chk(coll_o == 0, "R10 clear", coll_o, 0);

    // R8 collisions at chosen points
    coll_mid(0, 0, 0);
    coll_mid(1, 1, 30);
    for (int i = 0; i < 4; i++)
      coll_mid(1'($urandom), 1'($urandom), $urandom_range(0, 30));

    // Random transfers
    for (int i = 0; i < 40; i++)
      xfer(1'($urandom), 1'($urandom), $urandom_range(0, 7), $urandom_range(0, 7),
           8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), 1);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule